// File: doc/BRIEF.md
# System Bus Ownership Arbiter

This block decides which master owns a shared system bus: a processor that signals through bus-request, bus-grant and bus-busy lines, or one of several expansion-slot masters. Each slot has its own request and grant pair. All handshake lines are active low, as they are on the pins. When nobody asks for the bus, the grant is left parked on the processor. The processor may then start a cycle without arbitrating first. A slot that asks for the bus has priority over this parked ownership. The processor's grant is withdrawn first, and the slot is granted only after that.

The processor is an ordinary client of a rotating-priority scheme, with the same standing as the slots. A slot keeps its grant for as long as it holds its request. After the slot releases, the arbiter keeps signalling bus-busy on its behalf until both halves of the transfer in flight have finished: the slot side and the system-bus side. Tri-state pin drivers, the data path and clock-domain crossing belong to other blocks. Here the busy drive is a plain enable output.

Top module: `sysbus_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the processor grant is asserted (low), every slot grant is negated (high) and the busy drive is off.
- R2: With no request from any client, the processor grant stays asserted (parked) and the busy drive stays off.
- R3: A processor request made while the bus is parked and no slot requests keeps the processor grant asserted for as long as the request is held. After the request is released, the processor grant is negated for at least one cycle.
- R4: A slot request that arrives while the bus is parked negates the processor grant from the next cycle on. A slot grant is asserted only in a cycle that follows a cycle in which the processor grant was negated.
- R5: No slot grant is issued while the processor's bus-busy input is asserted (low) at the deciding clock edge.
- R6: A granted slot keeps its grant for as long as it holds its request, and the busy drive is on in every cycle in which a slot grant is asserted.
- R7: After a slot releases its request, its grant is negated from the next cycle on. The busy drive stays on while either the slot-side or the system-side transfer-active input is high, and it turns off one cycle after both are low.
- R8: At most one slot grant is asserted at a time, and no slot grant is asserted together with the processor grant.
- R9: A slot grant never passes directly to another grant. At least one cycle with no slot grant asserted separates two tenures.
- R10: Clients are indexed 0 for the processor and i+1 for slot i. Each new grant goes to the first requesting client after the previous owner in ascending cyclic index order. After reset, the previous owner is index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_br_n | input | 1 | Processor bus request, active low |
| cpu_bb_n | input | 1 | Processor bus-busy (processor cycle in progress), active low |
| cpu_bg_n | output | 1 | Processor bus grant, active low |
| pci_req_n | input | N_SLOTS | Per-slot bus request, active low |
| pci_gnt_n | output | N_SLOTS | Per-slot bus grant, active low |
| dma_pci_act | input | 1 | Slot-side transfer still active |
| dma_sys_act | input | 1 | System-bus-side transfer still active |
| bb_drv | output | 1 | Drive bus-busy on behalf of a slot master |

## Verification
The assertions assume that masters behave as the protocol expects. A slot holds its request until it has been granted and has finished a tenure. The processor asserts its busy input only while it owns the bus, parked or explicit. The transfer-active inputs rise only during or straight after a slot tenure. The stimulus keeps to these rules. It emulates each master as a small responder that raises its request, waits for its grant, counts a fixed tenure and then releases. Busy and transfer-active levels are changed only from scripted windows around such tenures.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [2:0] {
    ST_PARK  = 3'd0,
    ST_CPU   = 3'd1,
    ST_GAP   = 3'd2,
    ST_PCI   = 3'd3,
    ST_DRAIN = 3'd4
  } arb_st_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int N_CLI = 6,
  parameter int IW    = $clog2(N_CLI)
) (
  input  logic [N_CLI-1:0] req,
  input  logic [IW-1:0]    last,
  output logic             hit,
  output logic [IW-1:0]    win
);
  // Scan from the farthest candidate to the nearest; the nearest requester wins.
  always_comb begin
    int cand;
    hit  = 1'b0;
    win  = '0;
    cand = 0;
    for (int off = N_CLI; off >= 1; off--) begin
      cand = (int'(last) + off) % N_CLI;
      if (req[cand]) begin
        hit = 1'b1;
        win = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/sba_out_decode.sv
module sba_out_decode
  import sba_pkg::*;
#(
  parameter int N_SLOTS = 5,
  parameter int IW      = 3
) (
  input  arb_st_e              st,
  input  logic [IW-1:0]        owner,
  output logic                 cpu_bg_n,
  output logic [N_SLOTS-1:0]   gnt_n,
  output logic                 bb_drv
);
  assign cpu_bg_n = !((st == ST_PARK) || (st == ST_CPU));
  assign bb_drv   = (st == ST_PCI) || (st == ST_DRAIN);

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_gnt
      assign gnt_n[g] = !((st == ST_PCI) && (owner == IW'(g + 1)));
    end
  endgenerate
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
  import sba_pkg::*;
#(
  parameter int N_SLOTS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_br_n,
  input  logic               cpu_bb_n,
  output logic               cpu_bg_n,
  input  logic [N_SLOTS-1:0] pci_req_n,
  output logic [N_SLOTS-1:0] pci_gnt_n,
  input  logic               dma_pci_act,
  input  logic               dma_sys_act,
  output logic               bb_drv
);
  localparam int N_CLI = N_SLOTS + 1;
  localparam int IW    = $clog2(N_CLI);

  // Client 0 is the processor, client i+1 is slot i.
  logic [N_CLI-1:0] cli_req;
  logic             slot_any;
  logic             pick_hit;
  logic [IW-1:0]    pick_win;
  arb_st_e          st_q, st_d;
  logic [IW-1:0]    last_q, last_d;

  assign cli_req  = {~pci_req_n, ~cpu_br_n};
  assign slot_any = |(~pci_req_n);

  sba_rr_pick #(.N_CLI(N_CLI), .IW(IW)) u_pick (
    .req  (cli_req),
    .last (last_q),
    .hit  (pick_hit),
    .win  (pick_win)
  );

  always_comb begin
    st_d   = st_q;
    last_d = last_q;
    unique case (st_q)
      ST_PARK: begin
        if (slot_any) begin
          st_d = ST_GAP;                 // withdraw the parked grant first
        end else if (!cpu_br_n) begin
          st_d   = ST_CPU;
          last_d = '0;
        end
      end
      ST_CPU: begin
        if (cpu_br_n) st_d = ST_GAP;
      end
      ST_GAP: begin
        if (cpu_bb_n) begin              // no processor cycle in flight
          if (pick_hit) begin
            last_d = pick_win;
            st_d   = (pick_win == '0) ? ST_CPU : ST_PCI;
          end else begin
            st_d = ST_PARK;
          end
        end
      end
      ST_PCI: begin
        if (!cli_req[last_q]) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!dma_pci_act && !dma_sys_act) st_d = ST_GAP;
      end
      default: st_d = ST_PARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PARK;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
    end
  end

  sba_out_decode #(.N_SLOTS(N_SLOTS), .IW(IW)) u_dec (
    .st       (st_q),
    .owner    (last_q),
    .cpu_bg_n (cpu_bg_n),
    .gnt_n    (pci_gnt_n),
    .bb_drv   (bb_drv)
  );

  // ---------------- assertions ----------------
  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pci_gnt_n) && !(!cpu_bg_n && (|(~pci_gnt_n))));

  assert_bb_with_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~pci_gnt_n)) |-> bb_drv);

  assert_gnt_after_bg_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|(~pci_gnt_n)) |-> $past(cpu_bg_n));

  assert_no_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_bb_n && (&pci_gnt_n)) |=> (&pci_gnt_n));

  assert_drain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_drv && (&pci_gnt_n) && (dma_pci_act || dma_sys_act)) |=> bb_drv);

  assert_no_handover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~pci_gnt_n)) |=> ((pci_gnt_n == $past(pci_gnt_n)) || (&pci_gnt_n)));

  assert_cpu_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CPU && !cpu_br_n) |=> !cpu_bg_n);

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_hold_chk
      assert_gnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_gnt_n[g] && !pci_req_n[g]) |=> !pci_gnt_n[g]);
    end
  endgenerate
endmodule

// File: tb/test_sysbus_arbiter.sv
module test_sysbus_arbiter;
  localparam int NS     = 5;
  localparam int NC     = NS + 1;
  localparam int CLK_PS = 10;
  localparam int TENURE = 3;

  localparam int M_PARK = 0, M_CPU = 1, M_GAP = 2, M_PCI = 3, M_DRAIN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_br_n = 1'b1;
  logic          cpu_bb_n = 1'b1;
  logic          cpu_bg_n;
  logic [NS-1:0] pci_req_n = '1;
  logic [NS-1:0] pci_gnt_n;
  logic          dma_pci_act = 1'b0;
  logic          dma_sys_act = 1'b0;
  logic          bb_drv;

  sysbus_arbiter #(.N_SLOTS(NS)) i_sysbus_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_br_n(cpu_br_n), .cpu_bb_n(cpu_bb_n),
    .cpu_bg_n(cpu_bg_n), .pci_req_n(pci_req_n), .pci_gnt_n(pci_gnt_n),
    .dma_pci_act(dma_pci_act), .dma_sys_act(dma_sys_act), .bb_drv(bb_drv)
  );

  always #(CLK_PS/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  // ---------- reference model (updated on the rising edge) ----------
  int m_ph = M_PARK;
  int m_last = 0;

  function automatic bit wants(int c);
    if (c == 0) return !cpu_br_n;
    return !pci_req_n[c-1];
  endfunction

  function automatic int choose(int from);
    for (int k = 1; k <= NC; k++) begin
      if (wants((from + k) % NC)) return (from + k) % NC;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = M_PARK;
      m_last = 0;
    end else begin
      case (m_ph)
        M_PARK: begin
          if (~pci_req_n != '0) m_ph = M_GAP;
          else if (!cpu_br_n) begin m_ph = M_CPU; m_last = 0; end
        end
        M_CPU: if (cpu_br_n) m_ph = M_GAP;
        M_GAP: begin
          if (cpu_bb_n) begin
            int w;
            w = choose(m_last);
            if (w < 0) m_ph = M_PARK;
            else begin m_last = w; m_ph = (w == 0) ? M_CPU : M_PCI; end
          end
        end
        M_PCI: if (pci_req_n[m_last-1]) m_ph = M_DRAIN;
        default: if (!dma_pci_act && !dma_sys_act) m_ph = M_GAP;
      endcase
    end
  end

  // ---------- knobs and bookkeeping ----------
  bit          cpu_want = 0;
  bit [NS-1:0] want = '0;
  bit          hold_busy = 0;
  bit          sys_busy = 0;
  int          drain_len = 0;
  int          act_cnt = 0;
  int          cpu_cnt = 0;
  int          ten_cnt [NS];
  int          glog[$];
  bit          prev_bg = 1'b0;
  logic [NS-1:0] prev_gnt = '1;
  int          busy_gnt_seen = 0;
  int          drain_obs = 0;
  int          bg_hi_cnt = 0;
  int          hold_bad = 0;
  int          rise_bad = 0;
  int          onehot_bad = 0;
  int          handover_bad = 0;
  int          cyc = 0;

  initial for (int i = 0; i < NS; i++) ten_cnt[i] = 0;

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (cyc > 50000) begin
        check(0, "R1 watchdog", cyc, 50000);
        finish_run();
      end
      if (rst_n) begin
        logic [NS-1:0] eg;
        eg = '1;
        if (m_ph == M_PCI) eg[m_last-1] = 1'b0;
        check(cpu_bg_n == !(m_ph == M_PARK || m_ph == M_CPU), "R3 bus grant",
              int'(cpu_bg_n), int'(!(m_ph == M_PARK || m_ph == M_CPU)));
        check(pci_gnt_n == eg, "R10 slot grants", int'(pci_gnt_n), int'(eg));
        check(bb_drv == (m_ph == M_PCI || m_ph == M_DRAIN), "R7 busy drive",
              int'(bb_drv), int'(m_ph == M_PCI || m_ph == M_DRAIN));
        // observations
        if (!cpu_bg_n && prev_bg && !cpu_br_n) glog.push_back(0);
        for (int i = 0; i < NS; i++)
          if (!pci_gnt_n[i] && prev_gnt[i]) glog.push_back(i + 1);
        if (!cpu_bb_n && (pci_gnt_n != '1)) busy_gnt_seen++;
        if ((pci_gnt_n == '1) && bb_drv) drain_obs++;
        if (cpu_bg_n) bg_hi_cnt++;
        if (!cpu_br_n && cpu_bg_n && m_ph == M_CPU) hold_bad++;
        if ((pci_gnt_n != '1) && (prev_gnt == '1) && !prev_bg) rise_bad++;
        if ($countones(~pci_gnt_n) > 1 || (!cpu_bg_n && pci_gnt_n != '1)) onehot_bad++;
        if ((prev_gnt != '1) && (pci_gnt_n != '1) && (pci_gnt_n != prev_gnt)) handover_bad++;
        prev_bg  = cpu_bg_n;
        prev_gnt = pci_gnt_n;
        // master responders
        if (cpu_want && cpu_br_n) cpu_br_n = 1'b0;
        else if (!cpu_br_n && !cpu_bg_n) begin
          cpu_cnt++;
          if (cpu_cnt >= TENURE) begin cpu_br_n = 1'b1; cpu_want = 0; cpu_cnt = 0; end
        end
        for (int i = 0; i < NS; i++) begin
          if (want[i] && pci_req_n[i]) pci_req_n[i] = 1'b0;
          else if (!pci_req_n[i] && !pci_gnt_n[i]) begin
            ten_cnt[i]++;
            if (ten_cnt[i] >= TENURE) begin
              pci_req_n[i] = 1'b1; want[i] = 0; ten_cnt[i] = 0; act_cnt = drain_len;
            end
          end
        end
        dma_pci_act = (act_cnt > 0);
        if (act_cnt > 0) act_cnt--;
        dma_sys_act = sys_busy;
        cpu_bb_n    = !hold_busy;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (want == '0 && !cpu_want && m_ph == M_PARK && cpu_br_n && pci_req_n == '1) break;
    end
    cycles(2);
  endtask

  initial begin
    cycles(1);
    // R1: reset values
    check(cpu_bg_n == 1'b0, "R1 grant in reset", int'(cpu_bg_n), 0);
    check(pci_gnt_n == '1, "R1 slot grants in reset", int'(pci_gnt_n), (1 << NS) - 1);
    check(bb_drv == 1'b0, "R1 busy drive in reset", int'(bb_drv), 0);
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
    check(cpu_bg_n == 1'b0 && bb_drv == 1'b0, "R1 first cycle after reset",
          int'({cpu_bg_n, bb_drv}), 0);
    // R2: idle parking
    cycles(5);
    check(cpu_bg_n == 1'b0, "R2 parked grant", int'(cpu_bg_n), 0);
    check(bb_drv == 1'b0, "R2 no busy drive when parked", int'(bb_drv), 0);

    // R10 scenario A: three slots at once from reset
    glog.delete();
    want = 5'b00111;
    wait_idle();
    check(glog.size() == 3, "R10 grant count A", glog.size(), 3);
    if (glog.size() == 3) begin
      check(glog[0] == 1 && glog[1] == 2 && glog[2] == 3, "R10 order A",
            glog[0] * 100 + glog[1] * 10 + glog[2], 123);
    end

    // R10 scenario B: processor and two slots after slot 2 owned last
    glog.delete();
    cpu_want = 1;
    want = 5'b00101;
    wait_idle();
    check(glog.size() == 3, "R10 grant count B", glog.size(), 3);
    if (glog.size() == 3) begin
      check(glog[0] == 0 && glog[1] == 1 && glog[2] == 3, "R10 order B",
            glog[0] * 100 + glog[1] * 10 + glog[2], 13);
    end

    // R5: processor busy blocks a slot grant
    busy_gnt_seen = 0;
    hold_busy = 1;
    cycles(2);
    want[1] = 1;
    cycles(6);
    check(busy_gnt_seen == 0, "R5 grant while busy", busy_gnt_seen, 0);
    check(cpu_bg_n == 1'b1, "R4 parked grant withdrawn on slot request", int'(cpu_bg_n), 1);
    hold_busy = 0;
    wait_idle();

    // R7: slot-side drain of three cycles
    drain_len = 3;
    drain_obs = 0;
    want[3] = 1;
    wait_idle();
    check(drain_obs == 3, "R7 drain cycles", drain_obs, 3);
    drain_len = 0;

    // R7: system-side activity keeps busy drive
    sys_busy = 1;
    want[4] = 1;
    wait_idle();
    cycles(4);
    check(bb_drv == 1'b1, "R7 busy held by system side", int'(bb_drv), 1);
    check(pci_gnt_n == '1, "R7 grant released", int'(pci_gnt_n), (1 << NS) - 1);
    sys_busy = 0;
    cycles(3);
    check(bb_drv == 1'b0, "R7 busy released", int'(bb_drv), 0);
    wait_idle();

    // R3: processor alone from parking
    bg_hi_cnt = 0;
    hold_bad = 0;
    cpu_want = 1;
    wait_idle();
    check(hold_bad == 0, "R3 grant held during request", hold_bad, 0);
    check(bg_hi_cnt == 1, "R3 grant gap after release", bg_hi_cnt, 1);

    // R6: long mixed traffic
    cpu_want = 1;
    want = 5'b11111;
    wait_idle();
    check(cpu_bg_n == 1'b0, "R2 parked after traffic", int'(cpu_bg_n), 0);

    check(rise_bad == 0, "R4 grant without prior gap", rise_bad, 0);
    check(onehot_bad == 0, "R8 overlapping grants", onehot_bad, 0);
    check(handover_bad == 0, "R9 direct handover", handover_bad, 0);
    check(bb_drv == 1'b0, "R6 busy drive idle at end", int'(bb_drv), 0);
    finish_run();
  end
endmodule